// File: doc/BRIEF.md
# Task-Priority Interrupt Gate

This block sits between a set of pending external interrupt sources and the processor core. Each source slot reports whether it is pending and which 8-bit vector it carries. The upper four bits of a vector give its priority class. A 4-bit threshold register, written by software, sets the level at or below which classes are held back. Among the pending vectors whose class is strictly above the threshold, the gate presents the highest vector number to the core on a request line.

Software raises the threshold around critical work to hold off low-priority interrupts, then lowers it again afterwards. A held-back source is never dropped by the gate. As long as its pending input stays high, it is offered again as soon as the threshold falls below its class. A vector that has been offered to the core stays on the request line, unchanged, until the core acknowledges it. A later rise of the threshold does not withdraw it.

Top module: `prio_gate`

## Requirements
- R1: After reset the threshold is 0 and `irq_req` is low when nothing is pending. A pending vector of class 1 (for example 0x10) is then delivered without any threshold write.
- R2: The class of a vector is bits [7:4]. A pending vector is deliverable only when its class is strictly greater than the threshold. With threshold 5, vector 0x5F is held back and vector 0x60 is delivered.
- R3: Vectors of class 0 (0x00 to 0x0F) are never delivered, for any threshold.
- R4: With threshold 15, no vector is delivered.
- R5: When several deliverable vectors are pending, `irq_vec` shows the highest vector number among them. Vectors held back by the threshold take no part in this choice.
- R6: Once `irq_req` has been high at a clock edge without `core_ack`, it stays high with the same `irq_vec` until the edge at which `core_ack` is high. This holds even if the source stops pending or the threshold is raised meanwhile.
- R7: A threshold write (`thr_we` high, value on `thr_wdata`) takes effect at that clock edge. In the following cycle every comparison uses the new value, so a held-back pending vector whose class now exceeds the threshold is requested in that cycle.
- R8: On the edge where `core_ack` meets a presented vector, the hold is released. In the next cycle the highest remaining deliverable vector is presented, with no idle cycle.
- R9: `core_ack` while `irq_req` is low has no effect: a vector that becomes pending afterwards is presented at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 4 | New threshold value |
| src_pend | input | NUM_SRC | Pending flag of each source slot |
| src_vec | input | NUM_SRC*8 | Vector of each slot, slot i in bits [8i+7:8i] |
| core_ack | input | 1 | Core accepts the presented vector |
| irq_req | output | 1 | A vector is offered to the core |
| irq_vec | output | 8 | The offered vector |

## Verification
The bench builds the gate with the default of eight source slots. This gives a selection tree three levels deep, with empty padding only when the count is changed. Eight slots leave room to fill several slots at once with vectors that straddle the threshold from both sides, and to keep a blocked vector pending while a held vector waits for acknowledgement. That brings the boundary classes 0, the threshold itself, threshold plus one and 15 into reach, together with the hand-off from one acknowledged vector to the next.

// File: rtl/prio_gate_pkg.sv
package prio_gate_pkg;

    localparam int unsigned VEC_W = 8;
    localparam int unsigned CLS_W = 4;
    localparam int unsigned CLS_LSB = VEC_W - CLS_W;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CLS_W-1:0] cls_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
    } cand_t;

    function automatic cls_t class_of(input vec_t v);
        return v[VEC_W-1:CLS_LSB];
    endfunction

    function automatic logic passes(input vec_t v, input cls_t thr);
        return class_of(v) > thr;
    endfunction

    function automatic cand_t pick_higher(input cand_t a, input cand_t b);
        if (a.valid && (!b.valid || a.vec >= b.vec))
            return a;
        return b;
    endfunction

endpackage

// File: rtl/pg_thresh_reg.sv
module pg_thresh_reg
    import prio_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  cls_t wdata,
    output cls_t thr_q
);

    always_ff @(posedge clk) begin
        if (rst)
            thr_q <= '0;
        else if (we)
            thr_q <= wdata;
    end

endmodule

// File: rtl/pg_class_filter.sv
module pg_class_filter
    import prio_gate_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0]       pend,
    input  logic [NUM_SRC*VEC_W-1:0] vecs,
    input  cls_t                     thr,
    output cand_t                    leaf [NUM_SRC]
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        vec_t v;
        assign v = vecs[i*VEC_W +: VEC_W];
        assign leaf[i].valid = pend[i] && passes(v, thr);
        assign leaf[i].vec   = v;
    end

endmodule

// File: rtl/pg_max_tree.sv
module pg_max_tree
    import prio_gate_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8
) (
    input  cand_t leaf [NUM_SRC],
    output cand_t best
);

    localparam int unsigned LVLS  = $clog2(NUM_SRC);
    localparam int unsigned WIDE  = 1 << LVLS;
    localparam int unsigned NODES = 2 * WIDE - 1;

    cand_t node [NODES];

    for (genvar g = 0; g < WIDE; g++) begin : g_leaf
        if (g < NUM_SRC) begin : g_real
            assign node[WIDE-1+g] = leaf[g];
        end else begin : g_pad
            assign node[WIDE-1+g] = '0;
        end
    end

    for (genvar n = 0; n < WIDE - 1; n++) begin : g_node
        assign node[n] = pick_higher(node[2*n+1], node[2*n+2]);
    end

    assign best = node[0];

endmodule

// File: rtl/pg_present.sv
module pg_present
    import prio_gate_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cand_t best,
    input  logic  ack,
    output logic  req,
    output vec_t  vec,
    output logic  lock_q
);

    vec_t lock_vec;

    assign req = lock_q | best.valid;
    assign vec = lock_q ? lock_vec : best.vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q   <= 1'b0;
            lock_vec <= '0;
        end else if (req && ack) begin
            lock_q   <= 1'b0;
        end else if (req && !lock_q) begin
            lock_q   <= 1'b1;
            lock_vec <= best.vec;
        end
    end

endmodule

// File: rtl/prio_gate.sv
module prio_gate
    import prio_gate_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     thr_we,
    input  logic [CLS_W-1:0]         thr_wdata,
    input  logic [NUM_SRC-1:0]       src_pend,
    input  logic [NUM_SRC*VEC_W-1:0] src_vec,
    input  logic                     core_ack,
    output logic                     irq_req,
    output logic [VEC_W-1:0]         irq_vec
);

    cls_t  thr_q;
    cand_t leaf [NUM_SRC];
    cand_t best;
    logic  lock_q;

    pg_thresh_reg u_thr (
        .clk   (clk),
        .rst   (rst),
        .we    (thr_we),
        .wdata (thr_wdata),
        .thr_q (thr_q)
    );

    pg_class_filter #(.NUM_SRC(NUM_SRC)) u_filt (
        .pend (src_pend),
        .vecs (src_vec),
        .thr  (thr_q),
        .leaf (leaf)
    );

    pg_max_tree #(.NUM_SRC(NUM_SRC)) u_tree (
        .leaf (leaf),
        .best (best)
    );

    pg_present u_pres (
        .clk    (clk),
        .rst    (rst),
        .best   (best),
        .ack    (core_ack),
        .req    (irq_req),
        .vec    (irq_vec),
        .lock_q (lock_q)
    );

endmodule

// File: rtl/prio_gate_chk.sv
module prio_gate_chk
    import prio_gate_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic thr_we,
    input cls_t thr_wdata,
    input cls_t thr_q,
    input logic lock_q,
    input logic core_ack,
    input logic irq_req,
    input vec_t irq_vec
);

    // R1
    thr_reset_zero_chk: assert property (@(posedge clk)
        rst |=> (thr_q == '0));

    // R2
    new_offer_above_thr_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !lock_q) |-> (class_of(irq_vec) > thr_q));

    // R3
    no_class_zero_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (class_of(irq_vec) != '0));

    // R4
    thr_max_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        ((thr_q == '1) && !lock_q) |-> !irq_req);

    // R6
    offer_held_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !core_ack) |=> (irq_req && $stable(irq_vec)));

    // R7
    thr_write_next_edge_chk: assert property (@(posedge clk) disable iff (rst)
        thr_we |=> (thr_q == $past(thr_wdata)));

endmodule

bind prio_gate prio_gate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .thr_we    (thr_we),
    .thr_wdata (thr_wdata),
    .thr_q     (thr_q),
    .lock_q    (lock_q),
    .core_ack  (core_ack),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec)
);

// File: tb/prio_gate_test.sv
module prio_gate_test;

    localparam int unsigned NSRC = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              thr_we = 1'b0;
    logic [3:0]        thr_wdata = '0;
    logic [NSRC-1:0]   src_pend = '0;
    logic [NSRC*8-1:0] src_vec = '0;
    logic              core_ack = 1'b0;
    logic              irq_req;
    logic [7:0]        irq_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prio_gate #(.NUM_SRC(NSRC)) uut (
        .clk       (clk),
        .rst       (rst),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .src_pend  (src_pend),
        .src_vec   (src_vec),
        .core_ack  (core_ack),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_out(input string tag, input bit exp_req, input logic [7:0] exp_vec);
        @(negedge clk);
        n_chk++;
        if (irq_req !== exp_req || (exp_req && irq_vec !== exp_vec)) begin
            n_bad++;
            $display("FAIL %s: req=%0b vec=%02h, expected req=%0b vec=%02h",
                     tag, irq_req, irq_vec, exp_req, exp_vec);
        end
    endtask

    task automatic set_src(input int slot, input logic [7:0] v, input bit p);
        src_vec[slot*8 +: 8] = v;
        src_pend[slot] = p;
    endtask

    task automatic write_thr(input logic [3:0] v);
        tick();
        thr_we = 1'b1;
        thr_wdata = v;
        tick();
        thr_we = 1'b0;
    endtask

    task automatic do_reset();
        tick();
        rst = 1'b1;
        thr_we = 1'b0;
        core_ack = 1'b0;
        src_pend = '0;
        src_vec = '0;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        expect_out("R1 idle after reset", 1'b0, 8'h00);
        tick();
        set_src(2, 8'h10, 1'b1);
        expect_out("R1 class 1 passes reset threshold", 1'b1, 8'h10);
    endtask

    task automatic t_class_boundary();
        do_reset();
        write_thr(4'd5);
        set_src(0, 8'h5F, 1'b1);
        expect_out("R2 class equal to threshold held", 1'b0, 8'h00);
        tick();
        expect_out("R2 still held next cycle", 1'b0, 8'h00);
        tick();
        set_src(1, 8'h60, 1'b1);
        expect_out("R2 class above threshold delivered", 1'b1, 8'h60);
    endtask

    task automatic t_class_zero();
        do_reset();
        tick();
        set_src(3, 8'h0F, 1'b1);
        set_src(4, 8'h00, 1'b1);
        expect_out("R3 class 0 never delivered", 1'b0, 8'h00);
    endtask

    task automatic t_thr_max();
        do_reset();
        write_thr(4'd15);
        set_src(0, 8'hFF, 1'b1);
        set_src(5, 8'hF0, 1'b1);
        expect_out("R4 threshold 15 blocks all", 1'b0, 8'h00);
    endtask

    task automatic t_highest();
        do_reset();
        write_thr(4'd9);
        set_src(0, 8'h31, 1'b1);
        set_src(1, 8'h9A, 1'b1);
        set_src(6, 8'hA2, 1'b1);
        set_src(7, 8'h45, 1'b1);
        expect_out("R5 highest deliverable among mix", 1'b1, 8'hA2);
        do_reset();
        tick();
        set_src(0, 8'h31, 1'b1);
        set_src(3, 8'h9A, 1'b1);
        set_src(5, 8'h97, 1'b1);
        set_src(7, 8'h45, 1'b1);
        expect_out("R5 highest vector with threshold 0", 1'b1, 8'h9A);
    endtask

    task automatic t_hold_and_lower();
        do_reset();
        tick();
        set_src(0, 8'h70, 1'b1);
        expect_out("R6 first offer", 1'b1, 8'h70);
        tick();
        set_src(0, 8'h70, 1'b0);
        set_src(1, 8'hE0, 1'b1);
        thr_we = 1'b1;
        thr_wdata = 4'd15;
        expect_out("R6 held after source drops", 1'b1, 8'h70);
        tick();
        thr_we = 1'b0;
        expect_out("R6 held after threshold raised", 1'b1, 8'h70);
        tick();
        core_ack = 1'b1;
        expect_out("R6 held in ack cycle", 1'b1, 8'h70);
        tick();
        core_ack = 1'b0;
        expect_out("R4 pending 0xE0 blocked after ack", 1'b0, 8'h00);
        write_thr(4'd0);
        expect_out("R7 blocked vector released after lowering", 1'b1, 8'hE0);
    endtask

    task automatic t_lower_step();
        do_reset();
        write_thr(4'd12);
        set_src(4, 8'hB3, 1'b1);
        expect_out("R7 class 11 under threshold 12", 1'b0, 8'h00);
        write_thr(4'd11);
        expect_out("R7 threshold 11 still holds class 11", 1'b0, 8'h00);
        tick();
        thr_we = 1'b1;
        thr_wdata = 4'd10;
        expect_out("R7 no effect before write edge", 1'b0, 8'h00);
        tick();
        thr_we = 1'b0;
        expect_out("R7 delivered in cycle after write", 1'b1, 8'hB3);
    endtask

    task automatic t_handoff();
        do_reset();
        tick();
        set_src(2, 8'h50, 1'b1);
        set_src(5, 8'h80, 1'b1);
        expect_out("R8 higher offered first", 1'b1, 8'h80);
        tick();
        core_ack = 1'b1;
        expect_out("R8 offer before ack edge", 1'b1, 8'h80);
        tick();
        core_ack = 1'b0;
        set_src(5, 8'h80, 1'b0);
        expect_out("R8 next vector without idle cycle", 1'b1, 8'h50);
    endtask

    task automatic t_stray_ack();
        do_reset();
        tick();
        core_ack = 1'b1;
        expect_out("R9 no request with stray ack", 1'b0, 8'h00);
        tick();
        core_ack = 1'b0;
        set_src(1, 8'h42, 1'b1);
        expect_out("R9 vector offered after stray ack", 1'b1, 8'h42);
        tick();
        expect_out("R9 offer held", 1'b1, 8'h42);
    endtask

    initial begin
        t_reset_state();
        t_class_boundary();
        t_class_zero();
        t_thr_max();
        t_highest();
        t_hold_and_lower();
        t_lower_step();
        t_handoff();
        t_stray_ack();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule